// File: doc/BRIEF.md
# Event Interrupter with Moderation

This block turns event-ready pulses from a host controller's event logic into interrupts for software. It holds an interrupt-pending flag and an interrupt-enable flag, a programmable moderation interval with a countdown, and an event-handler-busy flag. When the countdown is at zero, an event sets pending. A pending, enabled interrupter that is not busy then issues an interrupt and sets busy. The interrupt is either a single message write, offered on a valid/ready handshake, or a level line.

In message mode, pending clears itself when the message write completes. A handler that reads the management register therefore normally sees only the enable bit (0x2). Busy stays set until software clears it with a write-1-to-clear to the dequeue register. While busy is set, a new event can raise pending again, but no interrupt goes out. Each issue reloads the countdown from the interval. The countdown then steps down once per tick pulse and stops at zero. An event that arrives while the countdown is nonzero is held until the countdown reaches zero.

Software reaches four word registers through a write strobe and a combinational read port. Address 0 is management, address 1 is moderation, address 2 is the dequeue register with busy, and address 3 is reserved.

Top module: `evt_intr_gen`

## Requirements
- R1: After reset, pending, enable, busy, interval and countdown are all 0, msg_valid is 0 and irq_level is 0.
- R2: Management register (address 0) reads {…0, enable at bit 1, pending at bit 0}. A write there loads enable from bit 1, and writing 1 to bit 0 clears pending. An event with countdown 0 sets pending at the next edge, and that set wins over a same-cycle software clear.
- R3: With msg_en high, a state that is pending, enabled, not busy and has no write outstanding raises msg_valid at the next edge. msg_valid holds until msg_ready is seen high.
- R4: The cycle in which msg_valid and msg_ready are both high completes the write: after that edge msg_valid and pending are 0, and address 0 reads 0x2.
- R5: Busy is set at the same edge that issues an interrupt. While busy is 1, no new message write starts, and a pending flag raised in that time stays 1.
- R6: Dequeue register (address 2) reads busy at bit 3. Writing 1 to bit 3 clears busy, and writing 0 there has no effect.
- R7: Moderation register (address 1): bits 15:0 are the read/write interval and bits 31:16 read the countdown. An issue reloads the countdown from the interval held before that edge. Each tick pulse lowers a nonzero countdown by 1, and the countdown stays at 0 once there. An event seen while the countdown is nonzero is held and sets pending at the edge after the countdown reaches zero.
- R8: With msg_en low, irq_level equals pending AND enable, no message write starts, and an issue still sets busy and reloads the countdown.
- R9: With enable 0, pending can still be set, but neither a message write nor irq_level occurs until enable is written to 1.
- R10: At most one message write is outstanding. An event that arrives while a write is outstanding, or while pending is already 1, is merged and causes no further interrupt.
- R11: Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_ready | input | 1 | Event-ready pulse from internal logic |
| tick | input | 1 | Moderation tick enable |
| msg_en | input | 1 | 1 selects message interrupts, 0 selects the level line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write accepted |
| irq_level | output | 1 | Level interrupt line |

## Verification
The bench targets the handler-visible case: pending must read 0 once the message write completes. A design that kept pending set would read 0x3 where 0x2 is expected. A second event during busy must leave pending at 1 with msg_valid low, and clearing busy must then release exactly one write. A design that dropped pending, or that ignored busy, shows up right away in the per-cycle comparison. Other stimulus targets events during an outstanding write, events during a nonzero countdown, the reload that uses the old interval when a write lands on the same edge, and toggling of enable and mode. A design that reissued, lost a held event, or wrapped the countdown would diverge from the model on msg_valid or on a register readback.

// File: rtl/intr_pkg.sv
package intr_pkg;
    typedef enum logic [1:0] {
        RA_MGMT = 2'd0,
        RA_MOD  = 2'd1,
        RA_DEQ  = 2'd2,
        RA_RSVD = 2'd3
    } reg_addr_e;

    localparam int unsigned PEND_BIT = 0;
    localparam int unsigned EN_BIT   = 1;
    localparam int unsigned BUSY_BIT = 3;
endpackage

// File: rtl/intr_moderator.sv
module intr_moderator #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             tick,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] count,
    output logic             at_zero
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } mod_st_t;

    mod_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reload)
            st_d.cnt = interval;
        else if (tick && (st_q.cnt != '0))
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign at_zero = (st_q.cnt == '0);
endmodule

// File: rtl/intr_msg_port.sv
module intr_msg_port (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic ready,
    output logic valid,
    output logic done
);
    typedef struct packed {
        logic vld;
    } msg_st_t;

    msg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (issue)
            st_d.vld = 1'b1;
        else if (st_q.vld && ready)
            st_d.vld = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.vld;
    assign done  = st_q.vld & ready;
endmodule

// File: rtl/evt_intr_gen.sv
module evt_intr_gen #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_ready,
    input  logic              tick,
    input  logic              msg_en,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic              irq_level
);
    import intr_pkg::*;

    localparam int unsigned PAD_W = DATA_W - 2 * CNT_W;

    typedef struct packed {
        logic             pend;
        logic             en;
        logic             busy;
        logic             held;
        logic [CNT_W-1:0] ival;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic             issue, msg_done, cnt_zero, pend_set;
    logic             wr_mgmt, wr_mod, wr_deq;
    logic [CNT_W-1:0] cnt_now;
    logic             ip_w, ie_w, ehb_w;
    logic [CNT_W-1:0] ival_w;

    assign wr_mgmt = reg_wr && (reg_addr_e'(reg_addr) == RA_MGMT);
    assign wr_mod  = reg_wr && (reg_addr_e'(reg_addr) == RA_MOD);
    assign wr_deq  = reg_wr && (reg_addr_e'(reg_addr) == RA_DEQ);

    assign issue    = st_q.pend && st_q.en && !st_q.busy && !msg_valid;
    assign pend_set = (evt_ready || st_q.held) && cnt_zero && !msg_valid;

    always_comb begin
        st_d = st_q;
        if (msg_done)
            st_d.pend = 1'b0;
        if (wr_mgmt && reg_wdata[PEND_BIT])
            st_d.pend = 1'b0;
        if (pend_set)
            st_d.pend = 1'b1;

        if (pend_set)
            st_d.held = 1'b0;
        else if (evt_ready && !st_q.pend && !msg_valid)
            st_d.held = 1'b1;

        if (wr_mgmt)
            st_d.en = reg_wdata[EN_BIT];
        if (wr_mod)
            st_d.ival = reg_wdata[CNT_W-1:0];

        if (issue)
            st_d.busy = 1'b1;
        else if (wr_deq && reg_wdata[BUSY_BIT])
            st_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    intr_moderator #(.CNT_W(CNT_W)) u_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (issue),
        .tick     (tick),
        .interval (st_q.ival),
        .count    (cnt_now),
        .at_zero  (cnt_zero)
    );

    intr_msg_port u_msg (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (issue && msg_en),
        .ready (msg_ready),
        .valid (msg_valid),
        .done  (msg_done)
    );

    assign irq_level = st_q.pend && st_q.en && !msg_en;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            RA_MGMT: begin
                reg_rdata[PEND_BIT] = st_q.pend;
                reg_rdata[EN_BIT]   = st_q.en;
            end
            RA_MOD:  reg_rdata = {{PAD_W{1'b0}}, cnt_now, st_q.ival};
            RA_DEQ:  reg_rdata[BUSY_BIT] = st_q.busy;
            default: reg_rdata = '0;
        endcase
    end

    assign ip_w   = st_q.pend;
    assign ie_w   = st_q.en;
    assign ehb_w  = st_q.busy;
    assign ival_w = st_q.ival;
endmodule

// File: rtl/evt_intr_chk.sv
module evt_intr_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic             ip,
    input logic             ie,
    input logic             ehb,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ival
);
    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid); // R3

    AST_DONE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> (!ip && !msg_valid)); // R4

    AST_ISSUE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> ehb); // R5

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ehb && !msg_valid) |=> !msg_valid); // R5

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> ((cnt == '0) || (cnt == $past(ival)))); // R7

    AST_NO_MSG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie && !msg_valid) |=> !msg_valid); // R9
endmodule

bind evt_intr_gen evt_intr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .ip        (ip_w),
    .ie        (ie_w),
    .ehb       (ehb_w),
    .cnt       (cnt_now),
    .ival      (ival_w)
);

// File: tb/sim_evt_intr_gen.sv
module sim_evt_intr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_ready = 1'b0, tick = 1'b0, msg_en = 1'b1, reg_wr = 1'b0, msg_ready = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid, irq_level;

    int vectors = 0, errors = 0;
    string tag = "R1";

    // reference state
    bit m_ip, m_ie, m_ehb, m_val, m_hold;
    int m_ival, m_cnt;

    always #5 clk = ~clk;

    evt_intr_gen u0 (
        .clk(clk), .rst_n(rst_n), .evt_ready(evt_ready), .tick(tick), .msg_en(msg_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .irq_level(irq_level)
    );

    always @(posedge clk) begin
        bit done, go, setp, nip, nhold, nehb, nval;
        int ncnt;
        if (!rst_n) begin
            m_ip <= 0; m_ie <= 0; m_ehb <= 0; m_val <= 0; m_hold <= 0; m_ival <= 0; m_cnt <= 0;
        end else begin
            done = m_val && msg_ready;
            go   = m_ip && m_ie && !m_ehb && !m_val;
            setp = (evt_ready || m_hold) && (m_cnt == 0) && !m_val;
            nip = m_ip;
            if (done) nip = 0;
            if (reg_wr && reg_addr == 0 && reg_wdata[0]) nip = 0;
            if (setp) nip = 1;
            nhold = m_hold;
            if (setp) nhold = 0;
            else if (evt_ready && !m_ip && !m_val) nhold = 1;
            nehb = m_ehb;
            if (go) nehb = 1;
            else if (reg_wr && reg_addr == 2 && reg_wdata[3]) nehb = 0;
            nval = m_val;
            if (go && msg_en) nval = 1;
            else if (done) nval = 0;
            ncnt = m_cnt;
            if (go) ncnt = m_ival;
            else if (tick && m_cnt > 0) ncnt = m_cnt - 1;
            m_ip <= nip; m_hold <= nhold; m_ehb <= nehb; m_val <= nval; m_cnt <= ncnt;
            if (reg_wr && reg_addr == 0) m_ie <= reg_wdata[1];
            if (reg_wr && reg_addr == 1) m_ival <= int'(reg_wdata[15:0]);
        end
    end

    function automatic logic [31:0] exp_rd();
        case (reg_addr)
            2'd0: return {30'd0, m_ie, m_ip};
            2'd1: return {m_cnt[15:0], m_ival[15:0]};
            2'd2: return {28'd0, m_ehb, 3'd0};
            default: return 32'd0;
        endcase
    endfunction

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp("msg_valid", {31'd0, msg_valid}, {31'd0, m_val});
        cmp("irq_level", {31'd0, irq_level}, {31'd0, m_ip & m_ie & ~msg_en});
        cmp("reg_rdata", reg_rdata, exp_rd());
    endtask

    task automatic idle(input int n);
        evt_ready = 0; reg_wr = 0; tick = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 0;
    endtask

    task automatic evt();
        evt_ready = 1; step(); evt_ready = 0;
    endtask

    task automatic peek(input logic [1:0] a);
        reg_addr = a; step();
    endtask

    bit wd_hit = 0;
    initial begin
        #1000000;
        wd_hit = 1;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1"; peek(0); peek(1); peek(2);
        // R11 reserved address
        tag = "R11"; wr(3, 32'hFFFF_FFFF); peek(3); peek(0); peek(2);
        // R2 / R3 / R4 first interrupt in message mode
        tag = "R2"; wr(0, 32'h2); peek(0); evt();
        tag = "R3"; msg_ready = 0; idle(4);
        tag = "R4"; msg_ready = 1; idle(1); msg_ready = 0; peek(0);
        // R5 busy blocks, pending remains set
        tag = "R5"; evt(); idle(5); peek(0); peek(2);
        // R6 write 0 ignored then W1C
        tag = "R6"; wr(2, 32'h0); peek(2); wr(2, 32'h8); peek(2); msg_ready = 1; idle(3); msg_ready = 0;
        // R10 events during outstanding write merged
        tag = "R10"; wr(2, 32'h8); evt(); evt(); evt(); msg_ready = 1; idle(1); msg_ready = 0;
        peek(0); wr(2, 32'h8); idle(4);
        // R7 moderation
        tag = "R7"; wr(1, 32'd4); wr(2, 32'h8); evt(); idle(2); msg_ready = 1; idle(1); msg_ready = 0;
        wr(2, 32'h8); evt(); peek(1);
        for (int i = 0; i < 6; i++) begin tick = 1; step(); end
        tick = 0; peek(1); idle(3); msg_ready = 1; idle(2); msg_ready = 0;
        // R8 level mode
        tag = "R8"; msg_en = 0; wr(2, 32'h8); evt(); idle(3); wr(0, 32'h3); idle(2); peek(2);
        // R9 enable low
        tag = "R9"; wr(1, 32'd0); wr(2, 32'h8); wr(0, 32'h0); evt(); idle(3); peek(0);
        msg_en = 1; idle(3); wr(0, 32'h2); idle(3); msg_ready = 1; idle(2);
        // random mix across all rules
        tag = "R5";
        for (int i = 0; i < 3000; i++) begin
            evt_ready = ($urandom_range(0, 3) == 0);
            tick      = ($urandom_range(0, 1) == 0);
            msg_ready = ($urandom_range(0, 2) != 0);
            if (($urandom_range(0, 50)) == 0) msg_en = ~msg_en;
            reg_wr    = ($urandom_range(0, 7) == 0);
            reg_addr  = 2'($urandom_range(0, 3));
            reg_wdata = {$urandom} & 32'h0000_000F | (reg_addr == 1 ? 32'd0 : 32'd2);
            step();
        end
        reg_wr = 0; evt_ready = 0; idle(2);
        if (!wd_hit) begin
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule